// File: doc/BRIEF.md
# Binary64 to Signed Integer Converter

This unit converts one IEEE-754 binary64 operand into a signed two's-complement integer carried in a 64-bit container. The target width can be the full 64 bits or a narrow 32 bits. The narrow result is sign-extended to fill the container. The rounding direction comes from a 2-bit mode field, and a truncate control overrides it. Each conversion reports three per-operation exception flags. These are merged into a sticky status accumulator, which also provides invalid and overall summary bits. When the caller asks for a record, the unit loads a 4-bit condition field from the summary bits.

A conversion passes through a small state machine. Its states are `S_IDLE`, `S_DECODE`, `S_ALIGN`, `S_ROUND` and `S_DONE`, and they are traversed in this order:

- `S_IDLE` moves to `S_DECODE` when `start_i` is seen.
- `S_DECODE` moves to `S_ALIGN` unconditionally, after the operand is split into its fields.
- `S_ALIGN` moves to `S_ROUND` unconditionally, after the significand is shifted to the integer point.
- `S_ROUND` moves to `S_DONE` unconditionally, after rounding, the range check and the flag update.
- `S_DONE` returns to `S_IDLE` unconditionally.

The operand and the controls are captured when the conversion starts. The trap-enable pair is read live.

Top module: `f2i_convert`

## Requirements
- R1: With `rmode_i` = 00 and `trunc_i` low, the unit rounds to nearest and breaks exact ties to the even integer. For example, 0.5 gives 0, 1.5 gives 2, 2.5 gives 2 and -2.5 gives -2.
- R2: The other `rmode_i` codes select directed rounding: 01 rounds toward zero, 10 rounds toward +infinity and 11 rounds toward -infinity.
- R3: With `trunc_i` high, the unit rounds toward zero whatever the value of `rmode_i`.
- R4: Any NaN returns the most negative value of the selected width and sets the invalid-conversion flag. A NaN whose top fraction bit is 0 (signaling) also sets the signaling-NaN flag. A NaN never sets the inexact flag.
- R5: In 64-bit mode, a rounded magnitude of 2^63 or more saturates. A positive value gives 0x7FFF_FFFF_FFFF_FFFF and a negative value below -2^63 gives 0x8000_0000_0000_0000. Infinities saturate the same way, and each of these cases sets the invalid-conversion flag. The value -2^63 itself converts exactly and raises no flag.
- R6: With `narrow_i` high, the result is sign-extended from 32 bits. Positive overflow gives 0x0000_0000_7FFF_FFFF, and negative overflow or a NaN gives 0xFFFF_FFFF_8000_0000. The range test uses the value after rounding.
- R7: `exc_o` is laid out as {invalid-conversion, signaling-NaN, inexact} in bits 2..0. Inexact is set when an in-range conversion discards a nonzero fraction. Inexact and invalid-conversion are never set together.
- R8: Both zeros convert to 0 with no flag. A nonzero subnormal sets inexact and converts to 0 under modes 00 and 01. Under a directed mode pointing away from zero, it converts to +1 or -1.
- R9: `sticky_o` is laid out as {FX, VX, CVI, SNAN, XX} in bits 4..0. A completed conversion ORs in its own flags. VX is set by any invalid flag and FX by any flag. The bits hold until `sticky_clr_i` is sampled high at a clock edge. Flags raised by a conversion that completes at that same edge are still kept.
- R10: `fex_o` is (VX and `trap_en_i[1]`) or (XX and `trap_en_i[0]`), taken from the sticky bits.
- R11: A conversion started with `record_i` high loads `cond_o` = {FX, FEX, VX, 0} in bits 3..0, using the sticky state that already includes that conversion's flags. Without a record, `cond_o` keeps its value.
- R12: `start_i` is accepted only in `S_IDLE`. `done_o` is a one-cycle pulse that is high at the fourth clock edge after the accepting edge. `result_o` and `exc_o` hold until the next completion, and a start request raised while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion |
| operand_i | input | 64 | Binary64 operand bits |
| rmode_i | input | 2 | Rounding direction code |
| trunc_i | input | 1 | Force rounding toward zero |
| narrow_i | input | 1 | Select the 32-bit target range |
| record_i | input | 1 | Load `cond_o` at completion |
| trap_en_i | input | 2 | Trap enables {invalid, inexact} |
| sticky_clr_i | input | 1 | Clear the sticky status bits |
| busy_o | output | 1 | A conversion is in flight |
| done_o | output | 1 | Completion pulse |
| result_o | output | 64 | Integer result |
| exc_o | output | 3 | Per-operation flags {CVI, SNAN, XX} |
| sticky_o | output | 5 | Sticky status {FX, VX, CVI, SNAN, XX} |
| fex_o | output | 1 | Enabled-exception summary |
| cond_o | output | 4 | Record condition {FX, FEX, VX, OX} |

## Verification
Faults in the state machine show up at the handshake. A skipped or stuck state moves the `done_o` pulse away from the fourth edge after the start, or stretches it, or stops `busy_o` from falling. A bad guard or sticky bit from the alignment stage shows in the result's low bit and in `exc_o[0]` at the same completion, and the quarter-step sweep exposes it in every rounding mode. A corrupted sticky accumulator is visible on `sticky_o`, `fex_o` and the next recorded `cond_o` from the completing edge onward, and stays wrong until it is cleared.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
    localparam int FP_W     = 64;
    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int MANT_W   = FRAC_W + 1;
    localparam int BIAS     = 1023;
    localparam int INT_W    = 64;
    localparam int NARROW_W = 32;
    localparam int GS_W     = MANT_W + 2;
    localparam int EXT_W    = MANT_W + GS_W;
    localparam int EXC_W    = 3;
    localparam int STK_W    = 5;
    localparam int COND_W   = 4;

    // exponent at which the significand LSB has weight one
    localparam logic [EXP_W-1:0] E_UNIT = EXP_W'(BIAS + FRAC_W);
    // smallest exponent whose magnitude is certain to reach 2^INT_W
    localparam logic [EXP_W-1:0] E_BIG  = EXP_W'(BIAS + FRAC_W + INT_W - MANT_W + 1);

    localparam int SK_FX = 4;
    localparam int SK_VX = 3;
    localparam int SK_CVI = 2;
    localparam int SK_SNAN = 1;
    localparam int SK_XX = 0;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_ALIGN,
        S_ROUND,
        S_DONE
    } state_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic              is_nan;
        logic              is_snan;
        logic              is_big;
    } unpk_t;

    typedef struct packed {
        logic             sign;
        logic [INT_W-1:0] mag;
        logic             guard;
        logic             sticky;
        logic             is_nan;
        logic             is_snan;
        logic             is_big;
    } algn_t;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             cvi;
        logic             snan;
        logic             xx;
    } cvt_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [FP_W-1:0] bits_i,
    output unpk_t           unpk_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              all_ones;

    always_comb begin
        exp_f          = bits_i[FP_W-2 -: EXP_W];
        frac_f         = bits_i[FRAC_W-1:0];
        all_ones       = &exp_f;
        unpk_o.sign    = bits_i[FP_W-1];
        unpk_o.exp     = exp_f;
        unpk_o.mant    = {(exp_f != '0), frac_f};
        unpk_o.is_nan  = all_ones && (frac_f != '0);
        unpk_o.is_snan = all_ones && (frac_f != '0) && !frac_f[FRAC_W-1];
        unpk_o.is_big  = all_ones || (exp_f >= E_BIG);
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  unpk_t unpk_i,
    output algn_t algn_o
);
    logic [EXP_W-1:0] lsh;
    logic [EXP_W-1:0] rsh;
    logic [EXP_W-1:0] rcl;
    logic [EXT_W-1:0] ext;
    logic [INT_W-1:0] lmag;

    always_comb begin
        lsh  = unpk_i.exp - E_UNIT;
        rsh  = E_UNIT - unpk_i.exp;
        // beyond GS_W every significand bit is already in the sticky field
        rcl  = (rsh > EXP_W'(GS_W)) ? EXP_W'(GS_W) : rsh;
        ext  = {unpk_i.mant, {GS_W{1'b0}}} >> rcl;
        lmag = INT_W'(unpk_i.mant) << lsh;

        algn_o.sign    = unpk_i.sign;
        algn_o.is_nan  = unpk_i.is_nan;
        algn_o.is_snan = unpk_i.is_snan;
        algn_o.is_big  = unpk_i.is_big;
        if (unpk_i.exp >= E_UNIT) begin
            algn_o.mag    = lmag;
            algn_o.guard  = 1'b0;
            algn_o.sticky = 1'b0;
        end else begin
            algn_o.mag    = INT_W'(ext[EXT_W-1:GS_W]);
            algn_o.guard  = ext[GS_W-1];
            algn_o.sticky = |ext[GS_W-2:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  algn_t  algn_i,
    input  rmode_e mode_i,
    input  logic   narrow_i,
    output cvt_t   cvt_o
);
    localparam logic [INT_W:0]   LIM_W   = (INT_W+1)'(1) << (INT_W-1);
    localparam logic [INT_W:0]   LIM_N   = (INT_W+1)'(1) << (NARROW_W-1);
    localparam logic [INT_W-1:0] PMAX_W  = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NMIN_W  = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] PMAX_N  = INT_W'({1'b0, {(NARROW_W-1){1'b1}}});
    localparam logic [INT_W-1:0] NMIN_N  = {{(INT_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    logic             inexact;
    logic             inc;
    logic [INT_W:0]   rmag;
    logic [INT_W:0]   lim;
    logic             ovf;
    logic [INT_W-1:0] smag;
    logic [INT_W-1:0] sval;
    logic [INT_W-1:0] pmax;
    logic [INT_W-1:0] nmin;

    always_comb begin
        inexact = algn_i.guard | algn_i.sticky;
        unique case (mode_i)
            RM_NEAR: inc = algn_i.guard & (algn_i.sticky | algn_i.mag[0]);
            RM_ZERO: inc = 1'b0;
            RM_PINF: inc = !algn_i.sign & inexact;
            RM_NINF: inc = algn_i.sign & inexact;
        endcase
        rmag = {1'b0, algn_i.mag} + (INT_W+1)'(inc);
        lim  = narrow_i ? LIM_N : LIM_W;
        pmax = narrow_i ? PMAX_N : PMAX_W;
        nmin = narrow_i ? NMIN_N : NMIN_W;
        // negative side may reach exactly the limit, positive side may not
        ovf  = algn_i.sign ? (rmag > lim) : (rmag >= lim);
        smag = rmag[INT_W-1:0];
        sval = algn_i.sign ? (~smag + INT_W'(1)) : smag;

        if (algn_i.is_nan) begin
            cvt_o.value = nmin;
            cvt_o.cvi   = 1'b1;
            cvt_o.snan  = algn_i.is_snan;
            cvt_o.xx    = 1'b0;
        end else if (algn_i.is_big || ovf) begin
            cvt_o.value = algn_i.sign ? nmin : pmax;
            cvt_o.cvi   = 1'b1;
            cvt_o.snan  = 1'b0;
            cvt_o.xx    = 1'b0;
        end else begin
            cvt_o.value = sval;
            cvt_o.cvi   = 1'b0;
            cvt_o.snan  = 1'b0;
            cvt_o.xx    = inexact;
        end
    end
endmodule

// File: rtl/f2i_status.sv
module f2i_status
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic              record_i,
    input  logic [1:0]        trap_en_i,
    input  logic              cvi_i,
    input  logic              snan_i,
    input  logic              xx_i,
    output logic [STK_W-1:0]  sticky_o,
    output logic              fex_o,
    output logic [COND_W-1:0] cond_o
);
    logic [STK_W-1:0]  stk_q;
    logic [STK_W-1:0]  stk_base;
    logic [STK_W-1:0]  stk_new;
    logic [STK_W-1:0]  stk_d;
    logic              fex_d;
    logic [COND_W-1:0] cond_q;

    always_comb begin
        stk_base = clr_i ? '0 : stk_q;
        stk_new  = '0;
        if (upd_i) begin
            stk_new[SK_FX]   = cvi_i | snan_i | xx_i;
            stk_new[SK_VX]   = cvi_i | snan_i;
            stk_new[SK_CVI]  = cvi_i;
            stk_new[SK_SNAN] = snan_i;
            stk_new[SK_XX]   = xx_i;
        end
        stk_d = stk_base | stk_new;
        fex_d = (stk_d[SK_VX] & trap_en_i[1]) | (stk_d[SK_XX] & trap_en_i[0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q  <= '0;
            cond_q <= '0;
        end else begin
            stk_q <= stk_d;
            if (upd_i && record_i) begin
                cond_q <= {stk_d[SK_FX], fex_d, stk_d[SK_VX], 1'b0};
            end
        end
    end

    assign sticky_o = stk_q;
    assign fex_o    = (stk_q[SK_VX] & trap_en_i[1]) | (stk_q[SK_XX] & trap_en_i[0]);
    assign cond_o   = cond_q;
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FP_W-1:0]   operand_i,
    input  logic [1:0]        rmode_i,
    input  logic              trunc_i,
    input  logic              narrow_i,
    input  logic              record_i,
    input  logic [1:0]        trap_en_i,
    input  logic              sticky_clr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [INT_W-1:0]  result_o,
    output logic [EXC_W-1:0]  exc_o,
    output logic [STK_W-1:0]  sticky_o,
    output logic              fex_o,
    output logic [COND_W-1:0] cond_o
);
    state_e           state_q;
    state_e           state_d;

    logic [FP_W-1:0]  op_q;
    rmode_e           rmode_q;
    logic             trunc_q;
    logic             narrow_q;
    logic             record_q;
    rmode_e           mode_eff;

    unpk_t            unpk_d;
    unpk_t            unpk_q;
    algn_t            algn_d;
    algn_t            algn_q;
    cvt_t             cvt_d;

    logic [INT_W-1:0] result_q;
    logic [EXC_W-1:0] exc_q;
    logic             upd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_DECODE;
            S_DECODE: state_d = S_ALIGN;
            S_ALIGN:  state_d = S_ROUND;
            S_ROUND:  state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (state_q != S_IDLE);
        done_o = (state_q == S_DONE);
        upd    = (state_q == S_ROUND);
    end

    assign mode_eff = trunc_q ? RM_ZERO : rmode_q;

    f2i_unpack u_unpack (
        .bits_i (op_q),
        .unpk_o (unpk_d)
    );

    f2i_align u_align (
        .unpk_i (unpk_q),
        .algn_o (algn_d)
    );

    f2i_round u_round (
        .algn_i   (algn_q),
        .mode_i   (mode_eff),
        .narrow_i (narrow_q),
        .cvt_o    (cvt_d)
    );

    // datapath registers, one stage per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            rmode_q  <= RM_NEAR;
            trunc_q  <= 1'b0;
            narrow_q <= 1'b0;
            record_q <= 1'b0;
            unpk_q   <= '0;
            algn_q   <= '0;
            result_q <= '0;
            exc_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        op_q     <= operand_i;
                        rmode_q  <= rmode_e'(rmode_i);
                        trunc_q  <= trunc_i;
                        narrow_q <= narrow_i;
                        record_q <= record_i;
                    end
                end
                S_DECODE: unpk_q <= unpk_d;
                S_ALIGN:  algn_q <= algn_d;
                S_ROUND: begin
                    result_q <= cvt_d.value;
                    exc_q    <= {cvt_d.cvi, cvt_d.snan, cvt_d.xx};
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    f2i_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (sticky_clr_i),
        .upd_i     (upd),
        .record_i  (record_q),
        .trap_en_i (trap_en_i),
        .cvi_i     (cvt_d.cvi),
        .snan_i    (cvt_d.snan),
        .xx_i      (cvt_d.xx),
        .sticky_o  (sticky_o),
        .fex_o     (fex_o),
        .cond_o    (cond_o)
    );

    assign result_o = result_q;
    assign exc_o    = exc_q;
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk
    import f2i_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [INT_W-1:0]  result_o,
    input logic [EXC_W-1:0]  exc_o,
    input logic [STK_W-1:0]  sticky_o,
    input logic              sticky_clr_i,
    input logic [COND_W-1:0] cond_o
);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o, 3) && !$past(busy_o, 4)));

    a_r12_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    a_r4_snan_with_cvi: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o[1]) |-> exc_o[2]);

    a_r7_xx_excl_cvi: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(exc_o[2] && exc_o[0]));

    a_r9_fx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_o[SK_FX] && !sticky_clr_i) |=> sticky_o[SK_FX]);

    a_r9_fx_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (exc_o != '0)) |-> sticky_o[SK_FX]);

    a_r9_vx_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o[2]) |-> sticky_o[SK_VX]);

    a_r11_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cond_o) |-> done_o);
endmodule

bind f2i_convert f2i_convert_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .exc_o        (exc_o),
    .sticky_o     (sticky_o),
    .sticky_clr_i (sticky_clr_i),
    .cond_o       (cond_o)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        trunc_i = 1'b0;
    logic        narrow_i = 1'b0;
    logic        record_i = 1'b0;
    logic [1:0]  trap_en_i = '0;
    logic        sticky_clr_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] result_o;
    logic [2:0]  exc_o;
    logic [4:0]  sticky_o;
    logic        fex_o;
    logic [3:0]  cond_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    f2i_convert u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .rmode_i(rmode_i), .trunc_i(trunc_i), .narrow_i(narrow_i),
        .record_i(record_i), .trap_en_i(trap_en_i), .sticky_clr_i(sticky_clr_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .exc_o(exc_o),
        .sticky_o(sticky_o), .fex_o(fex_o), .cond_o(cond_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] op, input logic [1:0] rm, input logic tr,
                          input logic nw, input logic rec, output int lat);
        @(negedge clk);
        operand_i = op; rmode_i = rm; trunc_i = tr; narrow_i = nw; record_i = rec;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic clear_sticky();
        @(negedge clk);
        sticky_clr_i = 1'b1;
        @(negedge clk);
        sticky_clr_i = 1'b0;
    endtask

    // expected integer for k/4 under a rounding mode code
    function automatic longint qexp(input int k, input int rm);
        int fl;
        int rem;
        longint r;
        fl  = (k >= 0) ? k / 4 : -((-k + 3) / 4);
        rem = k - 4 * fl;
        case (rm)
            0: begin
                if (rem < 2) r = fl;
                else if (rem > 2) r = fl + 1;
                else r = (fl % 2 == 0) ? fl : fl + 1;
            end
            1: r = (k < 0 && rem != 0) ? fl + 1 : fl;
            2: r = (rem != 0) ? fl + 1 : fl;
            default: r = fl;
        endcase
        return r;
    endfunction

    task automatic special(input string tag, input logic [63:0] op, input logic [1:0] rm,
                           input logic nw, input logic [63:0] exp_res, input logic [2:0] exp_exc);
        int lat;
        run_op(op, rm, 1'b0, nw, 1'b0, lat);
        chk(tag, result_o, exp_res);
        chk(tag, {61'd0, exc_o}, {61'd0, exp_exc});
    endtask

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state, R12
        chk("R12 reset busy", {63'd0, busy_o}, 64'd0);
        chk("R12 reset done", {63'd0, done_o}, 64'd0);
        chk("R12 reset result", result_o, 64'd0);
        chk("R9 reset sticky", {59'd0, sticky_o}, 64'd0);
        chk("R11 reset cond", {60'd0, cond_o}, 64'd0);

        // quarter-step sweep over every mode, truncate and width
        for (int k = -41; k <= 41; k++) begin
            for (int rm = 0; rm < 4; rm++) begin
                for (int tr = 0; tr < 2; tr++) begin
                    for (int nw = 0; nw < 2; nw++) begin
                        longint e;
                        string tag;
                        e = qexp(k, (tr != 0) ? 1 : rm);
                        tag = (tr != 0) ? "R3 sweep" : ((rm == 0) ? "R1 sweep" : "R2 sweep");
                        run_op($realtobits(real'(k) / 4.0), 2'(rm), tr[0], nw[0], 1'b0, lat);
                        chk(tag, result_o, 64'(e));
                        chk("R7 sweep flags", {61'd0, exc_o},
                            {61'd0, 2'b00, ((k % 4) != 0)});
                    end
                end
            end
        end

        // latency, R12
        run_op($realtobits(3.0), 2'b00, 1'b0, 1'b0, 1'b0, lat);
        chk("R12 latency", 64'(lat), 64'd4);
        // start while busy is ignored, R12
        @(negedge clk);
        operand_i = $realtobits(3.0); rmode_i = 2'b00; trunc_i = 1'b0; narrow_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        operand_i = $realtobits(7.0);
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R12 busy start ignored", result_o, 64'd3);
        begin
            int extra;
            extra = 0;
            repeat (8) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            chk("R12 single completion", 64'(extra), 64'd0);
            chk("R12 result held", result_o, 64'd3);
        end

        // NaN, R4
        special("R4 qnan", 64'h7FF8_0000_0000_0000, 2'b00, 1'b0, 64'h8000_0000_0000_0000, 3'b100);
        special("R4 snan", 64'h7FF0_0000_0000_0001, 2'b10, 1'b0, 64'h8000_0000_0000_0000, 3'b110);
        special("R4 R6 snan narrow", 64'hFFF4_0000_0000_0000, 2'b00, 1'b1, 64'hFFFF_FFFF_8000_0000, 3'b110);
        // 64-bit range, R5
        special("R5 +inf", 64'h7FF0_0000_0000_0000, 2'b00, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 3'b100);
        special("R5 -inf", 64'hFFF0_0000_0000_0000, 2'b00, 1'b0, 64'h8000_0000_0000_0000, 3'b100);
        special("R5 2^63", 64'h43E0_0000_0000_0000, 2'b00, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 3'b100);
        special("R5 -2^63", 64'hC3E0_0000_0000_0000, 2'b00, 1'b0, 64'h8000_0000_0000_0000, 3'b000);
        special("R5 below -2^63", 64'hC3E0_0000_0000_0001, 2'b00, 1'b0, 64'h8000_0000_0000_0000, 3'b100);
        special("R5 top in range", 64'h43DF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 64'h7FFF_FFFF_FFFF_FC00, 3'b000);
        special("R5 large exact", $realtobits(4503599627370497.0), 2'b00, 1'b0, 64'd4503599627370497, 3'b000);
        // 32-bit range after rounding, R6
        special("R6 round up overflow", $realtobits(2147483647.5), 2'b10, 1'b1, 64'h0000_0000_7FFF_FFFF, 3'b100);
        special("R6 tie overflow", $realtobits(2147483647.5), 2'b00, 1'b1, 64'h0000_0000_7FFF_FFFF, 3'b100);
        special("R6 toward zero", $realtobits(2147483647.5), 2'b01, 1'b1, 64'h0000_0000_7FFF_FFFF, 3'b001);
        special("R6 wide no overflow", $realtobits(2147483647.5), 2'b10, 1'b0, 64'h0000_0000_8000_0000, 3'b001);
        special("R6 neg tie in range", $realtobits(-2147483648.5), 2'b00, 1'b1, 64'hFFFF_FFFF_8000_0000, 3'b001);
        special("R6 neg overflow", $realtobits(-2147483648.5), 2'b11, 1'b1, 64'hFFFF_FFFF_8000_0000, 3'b100);
        special("R6 neg small", $realtobits(-5.0), 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 3'b000);
        // zeros and subnormals, R8
        special("R8 +0", 64'h0000_0000_0000_0000, 2'b10, 1'b0, 64'd0, 3'b000);
        special("R8 -0", 64'h8000_0000_0000_0000, 2'b11, 1'b0, 64'd0, 3'b000);
        special("R8 denorm nearest", 64'h0000_0000_0000_0001, 2'b00, 1'b0, 64'd0, 3'b001);
        special("R8 denorm zero", 64'h000F_FFFF_FFFF_FFFF, 2'b01, 1'b0, 64'd0, 3'b001);
        special("R8 denorm up", 64'h0000_0000_0000_0001, 2'b10, 1'b0, 64'd1, 3'b001);
        special("R8 neg denorm down", 64'h8000_0000_0000_0001, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
        special("R8 neg denorm up", 64'h8000_0000_0000_0001, 2'b10, 1'b0, 64'd0, 3'b001);

        // sticky, enables and record, R9 R10 R11
        trap_en_i = 2'b00;
        clear_sticky();
        chk("R9 cleared", {59'd0, sticky_o}, 64'd0);
        run_op($realtobits(1.0), 2'b00, 1'b0, 1'b0, 1'b1, lat);
        chk("R9 exact leaves sticky", {59'd0, sticky_o}, 64'd0);
        chk("R11 record clean", {60'd0, cond_o}, 64'd0);
        run_op($realtobits(0.25), 2'b00, 1'b0, 1'b0, 1'b0, lat);
        chk("R9 inexact sets fx xx", {59'd0, sticky_o}, 64'h11);
        chk("R11 no record keeps cond", {60'd0, cond_o}, 64'd0);
        chk("R10 no enable", {63'd0, fex_o}, 64'd0);
        run_op($realtobits(2.0), 2'b00, 1'b0, 1'b0, 1'b0, lat);
        chk("R9 sticky held", {59'd0, sticky_o}, 64'h11);
        @(negedge clk);
        trap_en_i = 2'b01;
        #1;
        chk("R10 inexact enable", {63'd0, fex_o}, 64'd1);
        run_op(64'h7FF8_0000_0000_0000, 2'b00, 1'b0, 1'b0, 1'b1, lat);
        chk("R9 nan adds vx cvi", {59'd0, sticky_o}, 64'h1D);
        chk("R11 record after nan", {60'd0, cond_o}, 64'hE);
        @(negedge clk);
        trap_en_i = 2'b10;
        #1;
        chk("R10 invalid enable", {63'd0, fex_o}, 64'd1);
        clear_sticky();
        chk("R9 clear", {59'd0, sticky_o}, 64'd0);
        chk("R10 clear drops fex", {63'd0, fex_o}, 64'd0);
        chk("R11 cond kept after clear", {60'd0, cond_o}, 64'hE);
        run_op($realtobits(2.0), 2'b00, 1'b0, 1'b0, 1'b1, lat);
        chk("R11 record exact", {60'd0, cond_o}, 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R12 watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule